// File: doc/BRIEF.md
# Run-time configurable UART receiver with idle-character timeout

This block receives asynchronous serial characters. A clock enable marks sixteen sample points per bit period, and the serial input is sampled on those points. The character format is set at run time: 5 to 14 data bits, even, odd or no parity, and one or two stop bits. Each completed character is delivered as a right-aligned data word with a one-cycle valid strobe. A parity error flag and a framing error flag travel with the word.

A character that samples low from its start bit through its last stop bit is a line break, and it is not delivered as data. The receiver measures how long the line then stays low, in whole character times. When the line goes high it reports that count with a strobe of its own.

After each delivered word, a down-counter is loaded with a programmable maximum. Every complete idle character decrements it. An idle character is continuous high for one full character length, and that length follows the current format. When the counter reaches zero before the next character starts, a one-cycle timeout strobe closes the receive frame. A maximum of zero turns the timeout off.

Top module: `uart_rx_idle`

## Requirements
- R1: Data bits arrive least significant bit first and appear right-aligned in `word_data`, with every bit above the data length at zero. `cfg_data_len` selects 5 to 14 data bits. A value below 5 acts as 5, and a value above 14 acts as 14.
- R2: `cfg_parity` selects the parity mode: 2'b01 is even, 2'b10 is odd, and 2'b00 or 2'b11 is none. With even parity, the count of ones across the data and the parity bit must be even. With odd parity, that count must be odd. When parity is enabled and the received bit violates this rule, `err_parity` is 1 together with `word_valid`.
- R3: `cfg_two_stop` set to 1 selects two stop bits, and 0 selects one. When any stop bit samples low, the word is still delivered, with `err_frame` at 1. The receiver then waits for the line to go high before it hunts for a new start bit.
- R4: A low level on the line counts as a start bit only when it is still low at the eighth sample after the falling edge. A shorter low pulse produces no output and leaves the receiver ready for the next character.
- R5: When the start bit, all data bits, the parity bit and all stop bits of a character sample low, no word is delivered. When the line next samples high, `brk_valid` pulses for one cycle. `brk_len` then gives the number of complete character times the line was low, counting the break character itself as 1.
- R6: Each delivered word loads the idle counter with `cfg_max_idle`. Each complete idle character decrements the counter. When it reaches zero, `idle_timeout` pulses for one cycle. This happens at most once for each delivered word.
- R7: When `cfg_max_idle` is 0, `idle_timeout` never asserts, however long the line stays idle.
- R8: An idle character lasts 1 + data length + 1 (only when parity is enabled) + stop count bit periods, each bit period being 16 enable pulses. So 8 data bits, no parity and one stop bit give 10 bit periods, and 8 data bits, parity and two stop bits give 12.
- R9: After reset, every output strobe and flag is 0.
- R10: The receiver advances only on cycles with `tick_x16` high. No output strobe rises in the cycle after a cycle without a tick.
- R11: At most one of `word_valid`, `brk_valid` and `idle_timeout` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_x16 | input | 1 | Enable pulse, 16 per bit period |
| rxd | input | 1 | Serial input, idle high |
| cfg_data_len | input | 4 | Number of data bits (5..14, clamped) |
| cfg_parity | input | 2 | Parity mode: 01 even, 10 odd, 00/11 none |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_max_idle | input | 16 | Idle characters allowed before timeout; 0 turns the timeout off |
| word_valid | output | 1 | One-cycle strobe: a character was received |
| word_data | output | 14 | Received data, right-aligned |
| err_frame | output | 1 | A stop bit sampled low (valid with `word_valid`) |
| err_parity | output | 1 | Parity mismatch (valid with `word_valid`) |
| brk_valid | output | 1 | One-cycle strobe: a break ended |
| brk_len | output | 16 | Break length in character times (valid with `brk_valid`) |
| idle_timeout | output | 1 | One-cycle strobe: the idle maximum was reached |

## Verification
The bench sends characters at both length limits, at a clamped length setting, and under every parity and stop-bit setting. A bit-position or alignment fault would show up as corrupted or shifted data, and a parity sense error would flag clean characters or pass corrupted ones. It drives a bad first stop bit and a bad second stop bit, a sub-half-bit glitch, and breaks of one and of three character times. A design that skipped the second stop bit, took glitches as start bits, or miscounted the low time would give wrong flags, spurious words or a wrong break length. It times the idle timeout under two formats, and a design that left the parity or second stop bit out of the idle length would be late or early by whole bit periods. With the maximum at zero and long idle gaps, a design whose zero setting fails to disable the count would raise a stray strobe.

// File: rtl/urx_pkg.sv
package urx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ODD   = 2'b10,
    PAR_NONE2 = 2'b11
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_SHIFT,
    ST_WAITHI,
    ST_BREAK
  } rx_state_e;

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/urx_deframer.sv
module urx_deframer
  import urx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int MIN_DATA = 5,
  parameter int MAX_DATA = 14,
  parameter int LEN_W    = 4,
  parameter int BIDX_W   = 5,
  parameter int CHT_W    = 9,
  parameter int BRK_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                rx,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic [1:0]          cfg_parity,
  input  logic                cfg_two_stop,
  output logic                hunting,
  output logic [CHT_W-1:0]    char_ticks,
  output logic                word_valid,
  output logic [MAX_DATA-1:0] word_data,
  output logic                err_frame,
  output logic                err_parity,
  output logic                brk_valid,
  output logic [BRK_W-1:0]    brk_len
);
  localparam int SUB_W = $clog2(OSR);

  rx_state_e            state;
  logic [SUB_W-1:0]     sub;
  logic [BIDX_W-1:0]    bidx;
  logic [MAX_DATA-1:0]  shreg;
  logic                 par_acc, fe, all_low;
  logic [CHT_W-1:0]     brk_ticks;
  logic [BRK_W-1:0]     brk_cnt;

  // format decode
  logic [LEN_W-1:0]  eff_len;
  logic              par_en, par_odd;
  logic [BIDX_W-1:0] n_after, last_idx;

  always_comb begin
    if (cfg_len < LEN_W'(MIN_DATA))      eff_len = LEN_W'(MIN_DATA);
    else if (cfg_len > LEN_W'(MAX_DATA)) eff_len = LEN_W'(MAX_DATA);
    else                                 eff_len = cfg_len;
  end

  assign par_en   = (cfg_parity == PAR_EVEN) || (cfg_parity == PAR_ODD);
  assign par_odd  = (cfg_parity == PAR_ODD);
  assign n_after  = BIDX_W'(eff_len) + BIDX_W'(par_en) + BIDX_W'(1) + BIDX_W'(cfg_two_stop);
  assign last_idx = n_after - BIDX_W'(1);
  assign char_ticks = CHT_W'(n_after + BIDX_W'(1)) * CHT_W'(OSR);
  assign hunting  = (state == ST_HUNT);

  // per-sample next values
  logic                is_data, is_par, is_stop, is_last;
  logic [MAX_DATA-1:0] shreg_n;
  logic                par_n, fe_n, all_low_n;

  assign is_data = bidx < BIDX_W'(eff_len);
  assign is_par  = par_en && (bidx == BIDX_W'(eff_len));
  assign is_stop = !is_data && !is_par;
  assign is_last = (bidx == last_idx);

  always_comb begin
    shreg_n = shreg;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (is_data && (bidx == BIDX_W'(i))) shreg_n[i] = rx;
    end
  end

  assign par_n     = par_acc ^ ((is_data || is_par) & rx);
  assign fe_n      = fe | (is_stop & ~rx);
  assign all_low_n = all_low & ~rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_HUNT;
      sub        <= '0;
      bidx       <= '0;
      shreg      <= '0;
      par_acc    <= 1'b0;
      fe         <= 1'b0;
      all_low    <= 1'b0;
      brk_ticks  <= '0;
      brk_cnt    <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
      err_frame  <= 1'b0;
      err_parity <= 1'b0;
      brk_valid  <= 1'b0;
      brk_len    <= '0;
    end else begin
      word_valid <= 1'b0;
      err_frame  <= 1'b0;
      err_parity <= 1'b0;
      brk_valid  <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_HUNT: begin
            if (!rx) begin
              state <= ST_START;
              sub   <= '0;
            end
          end
          ST_START: begin
            if (sub == SUB_W'(OSR/2 - 1)) begin
              if (!rx) begin
                state   <= ST_SHIFT;
                sub     <= '0;
                bidx    <= '0;
                shreg   <= '0;
                par_acc <= 1'b0;
                fe      <= 1'b0;
                all_low <= 1'b1;
              end else begin
                state <= ST_HUNT;
              end
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
          ST_SHIFT: begin
            if (sub == SUB_W'(OSR - 1)) begin
              sub     <= '0;
              shreg   <= shreg_n;
              par_acc <= par_n;
              fe      <= fe_n;
              all_low <= all_low_n;
              bidx    <= bidx + BIDX_W'(1);
              if (is_last) begin
                if (all_low_n) begin
                  state     <= ST_BREAK;
                  brk_ticks <= '0;
                  brk_cnt   <= BRK_W'(1);
                end else begin
                  word_valid <= 1'b1;
                  word_data  <= shreg_n;
                  err_frame  <= fe_n;
                  err_parity <= par_en & (par_n ^ par_odd);
                  state      <= fe_n ? ST_WAITHI : ST_HUNT;
                end
              end
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
          ST_WAITHI: begin
            if (rx) state <= ST_HUNT;
          end
          ST_BREAK: begin
            if (rx) begin
              brk_valid <= 1'b1;
              brk_len   <= brk_cnt;
              state     <= ST_HUNT;
            end else if (brk_ticks == char_ticks - CHT_W'(1)) begin
              brk_ticks <= '0;
              if (brk_cnt != '1) brk_cnt <= brk_cnt + BRK_W'(1);
            end else begin
              brk_ticks <= brk_ticks + CHT_W'(1);
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/urx_idle_timer.sv
module urx_idle_timer #(
  parameter int CHT_W  = 9,
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx,
  input  logic              hunting,
  input  logic              word_done,
  input  logic [CHT_W-1:0]  char_ticks,
  input  logic [IDLE_W-1:0] max_idle,
  output logic              timeout
);
  logic [CHT_W-1:0]  run;
  logic [IDLE_W-1:0] down;
  logic              armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= '0;
      down    <= '0;
      armed   <= 1'b0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (word_done) begin
        down  <= max_idle;
        armed <= (max_idle != '0);
        run   <= '0;
      end else if (tick) begin
        if (!hunting || !rx) begin
          run <= '0;
        end else if (run == char_ticks - CHT_W'(1)) begin
          run <= '0;
          if (armed) begin
            down <= down - IDLE_W'(1);
            if (down == IDLE_W'(1)) begin
              timeout <= 1'b1;
              armed   <= 1'b0;
            end
          end
        end else begin
          run <= run + CHT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
  parameter int OSR      = 16,
  parameter int MIN_DATA = 5,
  parameter int MAX_DATA = 14,
  parameter int IDLE_W   = 16,
  parameter int BRK_W    = 16,
  parameter int SYNC_STG = 2,
  localparam int LEN_W   = $clog2(MAX_DATA + 1),
  localparam int BIDX_W  = $clog2(MAX_DATA + 4),
  localparam int CHT_W   = $clog2(OSR * (MAX_DATA + 4) + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_x16,
  input  logic                rxd,
  input  logic [LEN_W-1:0]    cfg_data_len,
  input  logic [1:0]          cfg_parity,
  input  logic                cfg_two_stop,
  input  logic [IDLE_W-1:0]   cfg_max_idle,
  output logic                word_valid,
  output logic [MAX_DATA-1:0] word_data,
  output logic                err_frame,
  output logic                err_parity,
  output logic                brk_valid,
  output logic [BRK_W-1:0]    brk_len,
  output logic                idle_timeout
);
  logic             rx_s;
  logic             hunting;
  logic [CHT_W-1:0] char_ticks;

  urx_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rxd),
    .q   (rx_s)
  );

  urx_deframer #(
    .OSR(OSR), .MIN_DATA(MIN_DATA), .MAX_DATA(MAX_DATA),
    .LEN_W(LEN_W), .BIDX_W(BIDX_W), .CHT_W(CHT_W), .BRK_W(BRK_W)
  ) u_deframe (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick_x16),
    .rx           (rx_s),
    .cfg_len      (cfg_data_len),
    .cfg_parity   (cfg_parity),
    .cfg_two_stop (cfg_two_stop),
    .hunting      (hunting),
    .char_ticks   (char_ticks),
    .word_valid   (word_valid),
    .word_data    (word_data),
    .err_frame    (err_frame),
    .err_parity   (err_parity),
    .brk_valid    (brk_valid),
    .brk_len      (brk_len)
  );

  urx_idle_timer #(.CHT_W(CHT_W), .IDLE_W(IDLE_W)) u_idle (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_x16),
    .rx         (rx_s),
    .hunting    (hunting),
    .word_done  (word_valid),
    .char_ticks (char_ticks),
    .max_idle   (cfg_max_idle),
    .timeout    (idle_timeout)
  );
endmodule

// File: rtl/urx_checks.sv
module urx_checks #(
  parameter int MIN_DATA = 5,
  parameter int MAX_DATA = 14,
  parameter int LEN_W    = 4,
  parameter int IDLE_W   = 16,
  parameter int BRK_W    = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                tick_x16,
  input logic [LEN_W-1:0]    cfg_data_len,
  input logic [IDLE_W-1:0]   cfg_max_idle,
  input logic                word_valid,
  input logic [MAX_DATA-1:0] word_data,
  input logic                brk_valid,
  input logic [BRK_W-1:0]    brk_len,
  input logic                idle_timeout
);
  logic [LEN_W-1:0] chk_len;
  always_comb begin
    if (cfg_data_len < LEN_W'(MIN_DATA))      chk_len = LEN_W'(MIN_DATA);
    else if (cfg_data_len > LEN_W'(MAX_DATA)) chk_len = LEN_W'(MAX_DATA);
    else                                      chk_len = cfg_data_len;
  end

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> ((word_data >> chk_len) == '0));

  a_r5_brk_len_nonzero: assert property (@(posedge clk) disable iff (rst)
    brk_valid |-> (brk_len != '0));

  a_r6_tmo_pulse: assert property (@(posedge clk) disable iff (rst)
    idle_timeout |=> !idle_timeout);

  a_r7_zero_off: assert property (@(posedge clk) disable iff (rst)
    idle_timeout |-> (cfg_max_idle != '0));

  a_r10_tick_gate: assert property (@(posedge clk) disable iff (rst)
    !tick_x16 |=> !(word_valid || brk_valid || idle_timeout));

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({word_valid, brk_valid, idle_timeout}));

  a_r9_quiet_reset: assert property (@(posedge clk)
    $past(rst) |-> !(word_valid || brk_valid || idle_timeout));
endmodule

bind uart_rx_idle urx_checks #(
  .MIN_DATA(MIN_DATA), .MAX_DATA(MAX_DATA), .LEN_W(LEN_W),
  .IDLE_W(IDLE_W), .BRK_W(BRK_W)
) u_checks (
  .clk          (clk),
  .rst          (rst),
  .tick_x16     (tick_x16),
  .cfg_data_len (cfg_data_len),
  .cfg_max_idle (cfg_max_idle),
  .word_valid   (word_valid),
  .word_data    (word_data),
  .brk_valid    (brk_valid),
  .brk_len      (brk_len),
  .idle_timeout (idle_timeout)
);

// File: tb/uart_rx_idle_test.sv
`timescale 1ns/1ps
module uart_rx_idle_test;
  localparam int BITC = 32;   // cycles per bit: a tick every other cycle, 16 ticks per bit
  localparam int TOL  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_x16 = 1'b0;
  logic        rxd = 1'b1;
  logic [3:0]  cfg_data_len = 4'd8;
  logic [1:0]  cfg_parity = 2'b00;
  logic        cfg_two_stop = 1'b0;
  logic [15:0] cfg_max_idle = 16'd0;
  logic        word_valid, err_frame, err_parity, brk_valid, idle_timeout;
  logic [13:0] word_data;
  logic [15:0] brk_len;

  uart_rx_idle uut (
    .clk(clk), .rst(rst), .tick_x16(tick_x16), .rxd(rxd),
    .cfg_data_len(cfg_data_len), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .cfg_max_idle(cfg_max_idle),
    .word_valid(word_valid), .word_data(word_data), .err_frame(err_frame),
    .err_parity(err_parity), .brk_valid(brk_valid), .brk_len(brk_len),
    .idle_timeout(idle_timeout)
  );

  always #2.5 clk = ~clk;   // 200 MHz

  always @(posedge clk) tick_x16 <= rst ? 1'b0 : ~tick_x16;

  typedef struct packed {
    logic [1:0]  kind;   // 0 word, 1 break, 2 timeout
    logic [13:0] data;
    logic        fe;
    logic        pe;
    logic [31:0] val;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    vectors = 0;
  int    fails   = 0;
  int    cyc     = 0;
  int    last_word_cyc = 0;
  bit    done = 0;

  task automatic push(input logic [1:0] k, input logic [13:0] d, input logic fe,
                      input logic pe, input int v, input string tag);
    exp_t e;
    e.kind = k; e.data = d; e.fe = fe; e.pe = pe; e.val = v;
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  task automatic take(input logic [1:0] k);
    exp_t  e;
    string t;
    int    d;
    vectors++;
    if (expq.size() == 0) begin
      fails++;
      $display("FAIL R11 unexpected event kind %0d at cycle %0d (expected none)", k, cyc);
      return;
    end
    e = expq.pop_front();
    t = tagq.pop_front();
    if (e.kind != k) begin
      fails++;
      $display("FAIL %s event kind got %0d exp %0d", t, k, e.kind);
    end else if (k == 2'd0) begin
      if (word_data != e.data || err_frame != e.fe || err_parity != e.pe) begin
        fails++;
        $display("FAIL %s word got %h fe%0b pe%0b exp %h fe%0b pe%0b",
                 t, word_data, err_frame, err_parity, e.data, e.fe, e.pe);
      end
    end else if (k == 2'd1) begin
      if (brk_len != e.val[15:0]) begin
        fails++;
        $display("FAIL %s break length got %0d exp %0d", t, brk_len, e.val);
      end
    end else begin
      d = cyc - last_word_cyc;
      if (d < int'(e.val) - TOL || d > int'(e.val) + TOL) begin
        fails++;
        $display("FAIL %s timeout delay got %0d exp %0d", t, d, e.val);
      end
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      if (word_valid)   begin last_word_cyc = cyc; take(2'd0); end
      if (brk_valid)    take(2'd1);
      if (idle_timeout) take(2'd2);
    end
  end

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    rxd = 1'b1;
    repeat (n * BITC) @(negedge clk);
  endtask

  task automatic set_cfg(input int len, input int pm, input int stops, input int mx);
    cfg_data_len = 4'(len);
    cfg_parity   = (pm == 1) ? 2'b01 : (pm == 2) ? 2'b10 : 2'b00;
    cfg_two_stop = (stops == 2);
    cfg_max_idle = 16'(mx);
  endtask

  // pm: 0 none, 1 even, 2 odd; bad_stop: 0 none, else index of the low stop bit
  task automatic send_char(input logic [13:0] d, input int len, input int pm,
                           input int stops, input bit flip, input int bad_stop,
                           input string tag);
    logic p;
    logic [13:0] m;
    p = 1'b0;
    m = '0;
    for (int i = 0; i < len; i++) begin p ^= d[i]; m[i] = d[i]; end
    if (pm == 2) p = ~p;
    if (flip) p = ~p;
    push(2'd0, m, bad_stop != 0, flip && pm != 0, 0, tag);
    send_bit(1'b0);
    for (int i = 0; i < len; i++) send_bit(d[i]);
    if (pm != 0) send_bit(p);
    for (int s = 1; s <= stops; s++) send_bit(bad_stop != s);
    send_bit(1'b1);
  endtask

  task automatic send_break(input int cbits, input int nchars, input string tag);
    push(2'd1, '0, 1'b0, 1'b0, nchars, tag);
    rxd = 1'b0;
    repeat (cbits * nchars * BITC) @(negedge clk);
    idle_bits(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, remaining expected %0d (expected 0)", expq.size());
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    vectors++;
    if (word_valid || brk_valid || idle_timeout || err_frame || err_parity) begin
      fails++;
      $display("FAIL R9 reset outputs got %0b%0b%0b%0b%0b exp 00000",
               word_valid, brk_valid, idle_timeout, err_frame, err_parity);
    end
    idle_bits(4);

    // R1 R10: basic 8N1 with the tick enable at half rate
    set_cfg(8, 0, 1, 0);
    send_char(14'h0A5, 8, 0, 1, 0, 0, "R1 8N1 a5");
    send_char(14'h03C, 8, 0, 1, 0, 0, "R10 8N1 3c");
    // R1: length limits and clamp (setting 3 acts as 5)
    set_cfg(5, 0, 1, 0);
    send_char(14'h3FF5, 5, 0, 1, 0, 0, "R1 5 bits");
    set_cfg(14, 0, 1, 0);
    send_char(14'h2D97, 14, 0, 1, 0, 0, "R1 14 bits");
    set_cfg(3, 0, 1, 0);
    send_char(14'h0016, 5, 0, 1, 0, 0, "R1 clamp to 5");
    // R2: parity modes, good and corrupted
    set_cfg(14, 1, 1, 0);
    send_char(14'h1234, 14, 1, 1, 0, 0, "R2 even ok");
    send_char(14'h0F0F, 14, 1, 1, 1, 0, "R2 even bad");
    set_cfg(7, 2, 2, 0);
    send_char(14'h0055, 7, 2, 2, 0, 0, "R2 odd ok");
    send_char(14'h0011, 7, 2, 2, 1, 0, "R2 odd bad");
    // R3: stop-bit errors
    set_cfg(8, 0, 1, 0);
    send_char(14'h0055, 8, 0, 1, 0, 1, "R3 stop low");
    idle_bits(2);
    set_cfg(8, 0, 2, 0);
    send_char(14'h00C3, 8, 0, 2, 0, 2, "R3 second stop low");
    idle_bits(2);
    send_char(14'h0081, 8, 0, 2, 0, 0, "R3 two stops ok");
    // R4: glitch of a quarter bit, then a normal character
    set_cfg(8, 0, 1, 0);
    rxd = 1'b0;
    repeat (BITC / 4) @(negedge clk);
    idle_bits(3);
    send_char(14'h00E7, 8, 0, 1, 0, 0, "R4 after glitch");
    // R5: breaks
    send_break(10, 1, "R5 break one char");
    send_break(10, 3, "R5 break three chars");
    send_char(14'h005A, 8, 0, 1, 0, 0, "R5 after break");
    // R6 R8: timeout after 2 idle chars of 10 bits
    set_cfg(8, 0, 1, 2);
    send_char(14'h0042, 8, 0, 1, 0, 0, "R6 word");
    push(2'd2, '0, 1'b0, 1'b0, 2 * 10 * BITC, "R6 timeout 8N1 max2");
    idle_bits(60);
    // R8: 8 bits, even parity, two stops -> 12-bit idle char
    set_cfg(8, 1, 2, 1);
    send_char(14'h0099, 8, 1, 2, 0, 0, "R8 word");
    push(2'd2, '0, 1'b0, 1'b0, 1 * 12 * BITC, "R8 timeout 8E2 max1");
    idle_bits(50);
    // R7: zero maximum
    set_cfg(8, 0, 1, 0);
    send_char(14'h0077, 8, 0, 1, 0, 0, "R7 word");
    idle_bits(400);

    done = 1;
    vectors++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL %s event missing, remaining got %0d exp 0", tagq[0], expq.size());
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule